// File: doc/BRIEF.md
# Pipelined Scan Register Access Port

This block is a serial data register that sits behind a test-access shift controller and gives it read and write reach into a bank of word-wide registers. Each scan carries one access: a 40-bit word made of a 32-bit data field, a 7-bit register address and a one-bit direction flag. At the update step the block either writes the data field to the addressed register, or issues a read of that register. On a read it latches the returned value and presents it in the data field of the following scan.

Reads are pipelined by one scan. The read strobe fires exactly once per read scan, so a register whose read has a side effect (a trace memory data port that advances its pointer) is touched exactly once per intended access. To fetch the result of the last read without another side effect, software ends a sequence with a read of the side-effect-free identification register at address 0. Addresses at or above the parameter `NUM_REGS` are unmapped: they raise no strobe, writes to them are dropped and reads of them return zero.

Top module: `scan_reg_port`

## Requirements
- R1: The chain is 40 bits, shifted right from `scan_in` toward `scan_out` one bit per cycle with `shift_en` high. The first 32 bits shifted in form the data field, least significant bit first. The next 7 form the address, least significant bit first. The last one is the direction flag, where 1 means write and 0 means read.
- R2: When `update` is sampled with the flag at 1 and a mapped address, `reg_wr` is high for exactly the next cycle. In that cycle `reg_addr` and `reg_wdata` carry the scanned address and data.
- R3: When `update` is sampled with the flag at 0 and a mapped address, `reg_rd` is high for exactly the next cycle, with `reg_addr` equal to the scanned address. A single update never raises both strobes.
- R4: The value on `reg_rdata` during the `reg_rd` cycle is held. On the next `capture`, it is loaded into chain bits 31:0, with bits 39:32 cleared. It then appears on `scan_out` during the first 32 shifts, least significant bit first, followed by 8 zero bits.
- R5: Consecutive read scans of a side-effecting address produce one strobe each. Each scan therefore returns the next successive word with none skipped or repeated.
- R6: A final read scan of address 0 returns the last pending word and adds no further access to the side-effecting address.
- R7: An address of `NUM_REGS` or more raises neither strobe. A read of such an address returns zero in the next scan.
- R8: After reset, `scan_out`, `reg_addr`, `reg_wdata`, `reg_wr` and `reg_rd` are all zero. No strobe is raised in any cycle other than the one after an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Shift the chain one bit this cycle |
| capture | input | 1 | Load the held read value into the chain |
| update | input | 1 | Decode the shifted word and issue the access |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out (chain bit 0) |
| reg_addr | output | 7 | Address presented to the register bank |
| reg_wdata | output | 32 | Write data to the register bank |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data from the bank, valid during `reg_rd` |

## Verification
On every cycle, the assertions check the following:
- each strobe follows an update and the direction it encoded;
- the two strobes are exclusive and never reach an unmapped address;
- the held word equals the bank's data from the strobe cycle;
- the chain stays still without shift or capture.

Only the bench scenarios can show the properties that span scans:
- the one-scan read latency;
- the unskipped walk through a side-effecting memory;
- the clean drain through address 0;
- the zero returned for unmapped reads.

// File: rtl/scan_acc_pkg.sv
// Shared definitions for the scan register access port.
// Assumes a single clock domain; all widths are set by the top's parameters.
package scan_acc_pkg;
    // Kind of access decoded at update time
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_VOID  = 2'd3
    } acc_kind_t;

    // Classify a scanned word: direction flag plus whether the address is mapped
    function automatic acc_kind_t classify(input logic wr_flag, input logic mapped);
        if (!mapped)      return ACC_VOID;
        else if (wr_flag) return ACC_WRITE;
        else              return ACC_READ;
    endfunction
endpackage

// File: rtl/scan_chain.sv
// Serial shift register of the access port.
// Shifts right (scan_in enters at the top bit, scan_out is bit 0); capture loads
// the held read word into the data field and clears the rest.
// Assumes shift_en and capture are never high together; capture wins if they are.
module scan_chain #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    localparam int CHAIN_W = DATA_W + ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               capture,
    input  logic               scan_in,
    input  logic [DATA_W-1:0]  cap_data,
    output logic               scan_out,
    output logic [CHAIN_W-1:0] chain
);
    logic [CHAIN_W-1:0] sr_q;

    // Capture, shift or hold the chain
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (capture)  sr_q <= {{(ADDR_W+1){1'b0}}, cap_data};
        else if (shift_en) sr_q <= {scan_in, sr_q[CHAIN_W-1:1]};
    end

    assign chain    = sr_q;
    assign scan_out = sr_q[0];

    // R1
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !capture) |=> $stable(sr_q));
endmodule

// File: rtl/scan_decode.sv
// Update-time decoder: turns the shifted word into one registered bank access.
// Drives address, write data and one-cycle strobes; flags unmapped reads so the
// holder can return zero. Assumes update is a single-cycle pulse.
module scan_decode
    import scan_acc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  logic              wr_flag,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              void_rd
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic      mapped;
    acc_kind_t kind;

    // Classify the scanned word
    always_comb begin
        mapped = {1'b0, addr_in} < LIMIT;
        kind   = classify(wr_flag, mapped);
    end

    // Register address, data and strobes on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            void_rd   <= 1'b0;
        end else begin
            reg_wr  <= update && (kind == ACC_WRITE);
            reg_rd  <= update && (kind == ACC_READ);
            void_rd <= update && (kind == ACC_VOID) && !wr_flag;
            if (update) begin
                reg_addr <= addr_in;
                if (kind == ACC_WRITE) reg_wdata <= data_in;
            end
        end
    end

    // R2
    wr_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(update) && $past(wr_flag)));
    // R3
    rd_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> ($past(update) && !$past(wr_flag)));
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, void_rd}));
    // R7
    mapped_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> ({1'b0, reg_addr} < LIMIT));
endmodule

// File: rtl/read_hold.sv
// Holds the word returned by the bank during a read strobe, or zero for an
// unmapped read, until the next capture moves it into the chain.
// Assumes the bank drives rdata combinationally from the address in the strobe cycle.
module read_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              void_rd,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] held
);
    // Latch the read result
    always_ff @(posedge clk) begin
        if (!rst_n)         held <= '0;
        else if (rd_strobe) held <= rdata;
        else if (void_rd)   held <= '0;
    end

    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_strobe) |-> (held == $past(rdata)));
    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(void_rd) |-> (held == '0));
endmodule

// File: rtl/scan_reg_port.sv
// Pipelined scan register access port: a 40-bit chain of data, address and
// direction that writes a register bank at update, or reads it at update and
// returns the value in the next scan.
// Assumes capture, shift_en and update come from an external shift controller,
// one at a time.
module scan_reg_port #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              capture,
    input  logic              update,
    input  logic              scan_in,
    output logic              scan_out,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CHAIN_W = DATA_W + ADDR_W + 1;

    logic [CHAIN_W-1:0] chain;
    logic [DATA_W-1:0]  held;
    logic               void_rd;

    scan_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .capture  (capture),
        .scan_in  (scan_in),
        .cap_data (held),
        .scan_out (scan_out),
        .chain    (chain)
    );

    scan_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .update    (update),
        .wr_flag   (chain[CHAIN_W-1]),
        .addr_in   (chain[DATA_W +: ADDR_W]),
        .data_in   (chain[DATA_W-1:0]),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .void_rd   (void_rd)
    );

    read_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (reg_rd),
        .void_rd   (void_rd),
        .rdata     (reg_rdata),
        .held      (held)
    );

    // R8
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> $past(update));
endmodule

// File: tb/test_scan_reg_port.sv
module test_scan_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID_WORD = 32'hA5C3_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0, capture = 1'b0, update = 1'b0, scan_in = 1'b0;
    logic        scan_out, reg_wr, reg_rd;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int compared = 0, mismatched = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_reg_port i_scan_reg_port (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
        .update(update), .scan_in(scan_in), .scan_out(scan_out),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Bank stub: id at 0, trace memory port at 4, plain registers elsewhere
    logic [31:0] bank_q [8];
    int          ram_ptr;

    function automatic logic [31:0] ram_word(input int idx);
        return 32'h1000_0000 + 32'(idx * 3);
    endfunction

    always_comb begin
        if (reg_addr == 7'd0)      reg_rdata = ID_WORD;
        else if (reg_addr == 7'd4) reg_rdata = ram_word(ram_ptr);
        else                       reg_rdata = bank_q[reg_addr[2:0]];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) bank_q[k] <= 32'h0;
            ram_ptr <= 0;
        end else begin
            if (reg_wr && reg_addr != 7'd0 && reg_addr != 7'd4) bank_q[reg_addr[2:0]] <= reg_wdata;
            if (reg_rd && reg_addr == 7'd4) ram_ptr <= ram_ptr + 1;
        end
    end

    // Reference model state
    logic [31:0] m_regs [8];
    logic [31:0] m_held;
    int          m_ptr;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock, then compare the strobes against the model's expectation
    task automatic tick(input bit ew, input bit er, input string req);
        @(negedge clk);
        check(reg_wr == ew, req, 64'(reg_wr), 64'(ew));
        check(reg_rd == er, req, 64'(reg_rd), 64'(er));
    endtask

    task automatic scan(input logic [31:0] d, input logic [6:0] a, input logic w, input string req);
        logic [39:0] word, got, exp;
        bit mapped;
        word   = {w, a, d};
        exp    = {8'h00, m_held};
        mapped = (a < 7'd8);
        capture = 1'b1; tick(0, 0, "R8"); capture = 1'b0;
        for (int i = 0; i < 40; i++) begin
            got[i] = scan_out; scan_in = word[i]; shift_en = 1'b1;
            tick(0, 0, "R8");
        end
        shift_en = 1'b0; scan_in = 1'b0; update = 1'b1;
        tick(w && mapped, !w && mapped, mapped ? (w ? "R2" : "R3") : "R7");
        update = 1'b0;
        if (mapped) check(reg_addr == a, w ? "R2" : "R3", 64'(reg_addr), 64'(a));
        if (mapped && w) check(reg_wdata == d, "R2", 64'(reg_wdata), 64'(d));
        check(got == exp, req, 64'(got), 64'(exp));
        // model update
        if (w) begin
            if (mapped && a != 7'd0 && a != 7'd4) m_regs[a[2:0]] = d;
        end else begin
            if (!mapped)        m_held = 32'h0;
            else if (a == 7'd0) m_held = ID_WORD;
            else if (a == 7'd4) begin m_held = ram_word(m_ptr); m_ptr++; end
            else                m_held = m_regs[a[2:0]];
        end
        tick(0, 0, "R8");
        tick(0, 0, "R8");
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_regs[k] = 32'h0;
        m_held = 32'h0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(scan_out == 1'b0, "R8", 64'(scan_out), 0);
        check(reg_addr == 7'd0, "R8", 64'(reg_addr), 0);
        check(reg_wdata == 32'd0, "R8", 64'(reg_wdata), 0);
        check(!reg_wr && !reg_rd, "R8", 64'({reg_wr, reg_rd}), 0);
        // R1 R2: write a register
        scan(32'h1234_5678, 7'd5, 1'b1, "R1");
        // R3 R4: read it back, data arrives one scan later
        scan(32'h0, 7'd5, 1'b0, "R4");
        // R5: walk the side-effecting memory port
        scan(32'h0, 7'd4, 1'b0, "R4");
        scan(32'h0, 7'd4, 1'b0, "R5");
        scan(32'h0, 7'd4, 1'b0, "R5");
        // R6: drain through the id register
        scan(32'h0, 7'd0, 1'b0, "R6");
        scan(32'h0, 7'd4, 1'b0, "R6");
        scan(32'h0, 7'd0, 1'b0, "R6");
        // R7: unmapped write and read
        scan(32'hFFFF_FFFF, 7'd9, 1'b1, "R6");
        scan(32'h0, 7'h7F, 1'b0, "R7");
        scan(32'h0, 7'd3, 1'b0, "R7");
        // R1 R2: alternating data pattern
        scan(32'hA5A5_5A5A, 7'd3, 1'b1, "R1");
        scan(32'h0, 7'd3, 1'b0, "R1");
        scan(32'h0, 7'd0, 1'b0, "R4");
        // R5: memory advanced exactly once per read scan
        check(ram_ptr == m_ptr, "R5", 64'(ram_ptr), 64'(m_ptr));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule